// File: doc/BRIEF.md
# Sixteen-bit ALU with condition codes

This block is the execute stage for the arithmetic and logic instructions of a small 16-bit load/store processor. Each cycle it may accept one 16-bit instruction word, qualified by a valid strobe. The opcode selects addition, bitwise AND or bitwise complement. The first operand is always a general register. The second operand is either another register or a sign-extended 5-bit immediate, and a single mode bit in the instruction picks between them. The eight-entry general register file sits inside the block.

Every register write also sets a one-hot negative/zero/positive status register from the value written. The write itself is echoed on a registered write port (enable, address, data), so that the surrounding pipeline can track results. Words whose opcode is not one of the three ALU opcodes pass through with no effect. Memory access, branching and fetch belong to other stages.

Top module: `alu16_exec`

## Requirements
- R1: While reset is held and on the first cycle after it, `wrEn` is 0 and the flags read N=0, Z=1, P=0. Every general register reads as zero until it is first written.
- R2: An accepted word with opcode bits [15:12]=0001 and mode bit [5]=0 adds the registers named by bits [8:6] and [2:0]. The sum is written to the register named by bits [11:9], and bits [4:3] are ignored.
- R3: When mode bit [5] is 1, bits [4:0] form a two's-complement immediate that is sign-extended to 16 bits and used in place of the second register. This holds for ADD and AND.
- R4: Opcode 0101 writes the bitwise AND of its two operands, with the second operand chosen as in R2 and R3.
- R5: Opcode 1001 writes the bitwise complement of the register named by bits [8:6]. Bits [5:0] of this instruction are 111111.
- R6: After every register write, exactly one flag is set. N is equal to bit 15 of the written value, Z is set when the value is zero, and P is set otherwise.
- R7: A word accepted at a clock edge with `instrValid` high makes `wrEn`, `wrAddr` (= bits [11:9]), `wrData` and the flags show its result right after that edge. The new register value is visible to a word accepted at the very next edge.
- R8: A word with any other opcode, or any word presented with `instrValid` low, writes no register. It leaves `wrEn` at 0 and the flags unchanged.
- R9: Addition wraps modulo 2^16 and has no overflow indication: 0x7FFF+1 gives 0x8000 with N set, and 0x8000+0x8000 gives 0 with Z set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 16 | Instruction word |
| wrEn | output | 1 | A general register was written at the last edge |
| wrAddr | output | 3 | Index of the register written |
| wrData | output | 16 | Value written |
| flagNeg | output | 1 | Last written value was negative |
| flagZero | output | 1 | Last written value was zero |
| flagPos | output | 1 | Last written value was positive |

## Verification
A corrupted flag register appears on the flag pins in the same cycle, because the flags are outputs of the state itself. A corrupted general register stays hidden until a later instruction names it as a source. It then shows up as a wrong `wrData` one cycle after that instruction is accepted. For this reason the bench sweeps every destination, source and immediate combination, and follows with a long pseudo-random stream, so that every register is read back soon after each write. A reference register model in the bench catches a bad value at the first instruction that reads it.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int INSTR_W = 16;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_AND = 2'd1,
    FN_NOT = 2'd2
  } aluFnE;

  // strobes from control to datapath
  typedef struct packed {
    logic  wrStrobe;
    logic  useImm;
    aluFnE fn;
  } ctrlS;

  // flag bit positions inside the status register
  localparam int FLAG_N = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_P = 0;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl import alu16_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       instrValid,
  input  logic [3:0] opcode,
  input  logic       modeBit,
  output ctrlS       ctrl
);

  always_comb begin
    ctrl.wrStrobe = 1'b0;
    ctrl.useImm   = 1'b0;
    ctrl.fn       = FN_ADD;
    unique case (opcode)
      OPC_ADD: begin
        ctrl.wrStrobe = instrValid;
        ctrl.useImm   = modeBit;
        ctrl.fn       = FN_ADD;
      end
      OPC_AND: begin
        ctrl.wrStrobe = instrValid;
        ctrl.useImm   = modeBit;
        ctrl.fn       = FN_AND;
      end
      OPC_NOT: begin
        ctrl.wrStrobe = instrValid;
        ctrl.fn       = FN_NOT;
      end
      default: ;
    endcase
  end

  // R8: nothing is written without a valid word
  assert_valid_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> !ctrl.wrStrobe);

  // R8: foreign opcodes never strobe a write
  assert_foreign_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (opcode != OPC_ADD && opcode != OPC_AND && opcode != OPC_NOT) |-> !ctrl.wrStrobe);

  // R3: immediate selection follows the mode bit on ADD and AND
  assert_imm_mode_R3: assert property (@(posedge clk) disable iff (rst)
    (instrValid && (opcode == OPC_ADD || opcode == OPC_AND)) |-> (ctrl.wrStrobe && ctrl.useImm == modeBit));

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath import alu16_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  parameter int IMM_W   = 5,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlS              ctrl,
  input  logic [ADDR_W-1:0] destSel,
  input  logic [ADDR_W-1:0] src1Sel,
  input  logic [ADDR_W-1:0] src2Sel,
  input  logic [IMM_W-1:0]  immField,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [2:0]        flags
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] regs [REG_CNT];
  logic [DATA_W-1:0] opA, opB, immExt, result;
  logic [2:0]        flagsNext;

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (ctrl.wrStrobe) begin
      regs[destSel] <= result;
    end
  end

  // operand selection
  assign immExt = {{EXT_W{immField[IMM_W-1]}}, immField};
  assign opA    = regs[src1Sel];
  assign opB    = ctrl.useImm ? immExt : regs[src2Sel];

  // function unit, sum wraps
  always_comb begin
    unique case (ctrl.fn)
      FN_AND:  result = opA & opB;
      FN_NOT:  result = ~opA;
      default: result = opA + opB;
    endcase
  end

  always_comb begin
    flagsNext         = '0;
    flagsNext[FLAG_N] = result[DATA_W-1];
    flagsNext[FLAG_Z] = (result == '0);
    flagsNext[FLAG_P] = !result[DATA_W-1] && (result != '0);
  end

  // registered write port and status
  always_ff @(posedge clk) begin
    if (rst) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
      flags  <= 3'b010;
    end else begin
      wrEn <= ctrl.wrStrobe;
      if (ctrl.wrStrobe) begin
        wrAddr <= destSel;
        wrData <= result;
        flags  <= flagsNext;
      end
    end
  end

  // R6: exactly one flag at all times
  assert_flags_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(flags) == 1);

  // R6: flags agree with the value shown on the write port
  assert_flags_match_R6: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (flags[FLAG_N] == wrData[DATA_W-1] && flags[FLAG_Z] == (wrData == '0)));

  // R8: an idle cycle keeps the status
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.wrStrobe |=> (!wrEn && $stable(flags)));

  // R7: write port names the decoded destination one cycle later
  assert_dest_follow_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.wrStrobe |=> (wrEn && wrAddr == $past(destSel)));

endmodule

// File: rtl/alu16_exec.sv
module alu16_exec import alu16_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [15:0]       instrWord,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              flagNeg,
  output logic              flagZero,
  output logic              flagPos
);

  localparam int IMM_W = 5;

  ctrlS       ctrl;
  logic [2:0] flags;

  alu16_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .opcode     (instrWord[15:12]),
    .modeBit    (instrWord[5]),
    .ctrl       (ctrl)
  );

  alu16_datapath #(
    .DATA_W  (DATA_W),
    .REG_CNT (REG_CNT),
    .IMM_W   (IMM_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .destSel  (instrWord[9 +: ADDR_W]),
    .src1Sel  (instrWord[6 +: ADDR_W]),
    .src2Sel  (instrWord[0 +: ADDR_W]),
    .immField (instrWord[IMM_W-1:0]),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .flags    (flags)
  );

  assign flagNeg  = flags[FLAG_N];
  assign flagZero = flags[FLAG_Z];
  assign flagPos  = flags[FLAG_P];

endmodule

// File: tb/alu16_exec_bench.sv
module alu16_exec_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [15:0] wrData;
  logic        flagNeg, flagZero, flagPos;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] regsM [8];
  logic [2:0]  flagsM;
  logic [31:0] lfsr = 32'hACE1_2357;

  always #10 clk = ~clk;

  alu16_exec u_alu16_exec (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .flagNeg(flagNeg), .flagZero(flagZero), .flagPos(flagPos)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] flagsOf(input logic [15:0] v);
    return {v[15], v == 16'h0, !v[15] && v != 16'h0};
  endfunction

  function automatic logic [15:0] mkReg(input logic [3:0] op, input int d, input int s1, input int s2);
    return {op, 3'(d), 3'(s1), 3'b000, 3'(s2)};
  endfunction

  function automatic logic [15:0] mkImm(input logic [3:0] op, input int d, input int s1, input int imm);
    return {op, 3'(d), 3'(s1), 1'b1, 5'(imm)};
  endfunction

  function automatic logic [15:0] mkNot(input int d, input int s1);
    return {4'b1001, 3'(d), 3'(s1), 6'b111111};
  endfunction

  // called at a negedge; presents a word, checks at the next negedge
  task automatic step(input logic [15:0] ins, input bit vld, input string tagIn);
    logic [15:0] a, b, res;
    logic        wr;
    string       tag;
    a  = regsM[ins[8:6]];
    b  = ins[5] ? {{11{ins[4]}}, ins[4:0]} : regsM[ins[2:0]];
    wr = vld;
    res = '0;
    case (ins[15:12])
      4'b0001: res = a + b;
      4'b0101: res = a & b;
      4'b1001: res = ~a;
      default: wr = 1'b0;
    endcase
    tag = tagIn;
    if (tag == "") begin
      if (!wr)                       tag = "R8";
      else if (ins[15:12] == 4'b1001) tag = "R5";
      else if (ins[5])               tag = "R3";
      else if (ins[15:12] == 4'b0101) tag = "R4";
      else                           tag = "R2";
    end
    instrWord  = ins;
    instrValid = vld;
    @(negedge clk);
    if (wr) begin
      chk(wrEn == 1'b1, "R7", "wrEn", 32'(wrEn), 32'd1);
      chk(wrAddr == ins[11:9], "R7", "wrAddr", 32'(wrAddr), 32'(ins[11:9]));
      chk(wrData == res, tag, "wrData", 32'(wrData), 32'(res));
      chk({flagNeg, flagZero, flagPos} == flagsOf(res), "R6", "flags",
          32'({flagNeg, flagZero, flagPos}), 32'(flagsOf(res)));
      regsM[ins[11:9]] = res;
      flagsM = flagsOf(res);
    end else begin
      chk(wrEn == 1'b0, "R8", "wrEn", 32'(wrEn), 32'd0);
      chk({flagNeg, flagZero, flagPos} == flagsM, "R8", "flags held",
          32'({flagNeg, flagZero, flagPos}), 32'(flagsM));
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) regsM[i] = '0;
    flagsM = 3'b010;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(wrEn == 1'b0, "R1", "wrEn in reset", 32'(wrEn), 32'd0);
    chk({flagNeg, flagZero, flagPos} == 3'b010, "R1", "flags in reset",
        32'({flagNeg, flagZero, flagPos}), 32'b010);
    rst = 1'b0;
    @(negedge clk);
    chk(wrEn == 1'b0, "R1", "wrEn after reset", 32'(wrEn), 32'd0);
    chk({flagNeg, flagZero, flagPos} == 3'b010, "R1", "flags after reset",
        32'({flagNeg, flagZero, flagPos}), 32'b010);
    // R1: every register reads zero
    for (int r = 0; r < 8; r++) step(mkImm(4'b0001, r, r, 0), 1'b1, "R1");

    // seed distinct values
    for (int r = 0; r < 8; r++) begin
      step(mkImm(4'b0001, r, r, 3 * r - 11), 1'b1, "");
      step(mkReg(4'b0001, r, r, (r + 3) % 8), 1'b1, "");
    end

    // R9: wrap-around cases
    step(mkImm(4'b0101, 2, 2, 0), 1'b1, "R4");
    step(mkImm(4'b0001, 2, 2, 1), 1'b1, "R3");
    for (int k = 0; k < 15; k++) step(mkReg(4'b0001, 2, 2, 2), 1'b1, "R9");
    step(mkNot(3, 2), 1'b1, "R5");
    step(mkImm(4'b0001, 4, 3, 1), 1'b1, "R9");
    chk(wrData == 16'h8000 && flagNeg, "R9", "0x7FFF+1", 32'(wrData), 32'h8000);
    step(mkReg(4'b0001, 5, 2, 2), 1'b1, "R9");
    chk(wrData == 16'h0000 && flagZero, "R9", "0x8000+0x8000", 32'(wrData), 32'h0);

    // R2/R4: all register triples, with complement between rows
    for (int d = 0; d < 8; d++)
      for (int s1 = 0; s1 < 8; s1++) begin
        for (int s2 = 0; s2 < 8; s2++) begin
          step(mkReg(4'b0001, d, s1, s2) | 16'h0018 * 16'(s2 & 1), 1'b1, "");
          step(mkReg(4'b0101, (d + 1) % 8, s1, s2), 1'b1, "");
        end
        step(mkNot(s1, (s1 + d) % 8), 1'b1, "");
      end

    // R3: every immediate on both opcodes
    for (int imm = 0; imm < 32; imm++)
      for (int d = 0; d < 8; d++) begin
        step(mkImm(4'b0001, d, (d + imm) % 8, imm), 1'b1, "");
        step(mkImm(4'b0101, (d + 5) % 8, d, imm), 1'b1, "");
      end

    // R8: foreign opcodes and valid-low words
    for (int op = 0; op < 16; op++) begin
      if (op != 1 && op != 5 && op != 9) step({4'(op), 12'hA5C}, 1'b1, "R8");
      step({4'(op), 12'h3F7}, 1'b0, "R8");
    end
    // R8: register state untouched, read back through the write port
    for (int r = 0; r < 8; r++) step(mkImm(4'b0001, r, r, 0), 1'b1, "R8");

    // pseudo-random back-to-back stream
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ins;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ins = {4'b0000, lfsr[15:4]};
      case (lfsr[2:0])
        3'd0, 3'd1: ins[15:12] = 4'b0001;
        3'd2, 3'd3: ins[15:12] = 4'b0101;
        3'd4:       begin ins[15:12] = 4'b1001; ins[5:0] = 6'h3F; end
        default:    ins[15:12] = lfsr[27:24];
      endcase
      if (ins[15:12] == 4'b1001) ins[5:0] = 6'h3F;
      step(ins, lfsr[17:16] != 2'b00, "");
    end

    instrValid = 1'b0;
    summary();
    $finish;
  end

endmodule